// File: doc/BRIEF.md
# Limit Alarm Monitor

This block watches five sampled monitoring channels. Each channel delivers an 8-bit unsigned ADC code, and a per-channel type bit decides how that code is judged. A voltage channel is compared against its own window, made of a low limit and a high limit. A temperature channel is compared against a high limit, and its alarm can be held active by a separate hysteresis threshold.

When a reading is out of bounds, a status bit for that channel is set and latched. The block drives one interrupt line, which is the OR of the status bits that are enabled.

Temperature channels behave differently in the two interrupt modes:
- **Mode 0:** a temperature alarm holds until the reading drops below the hysteresis value.
- **Mode 1:** a temperature alarm simply tracks the comparison against the high limit.

Writing a zero to the mode bit forces mode 0 and clears every pending alarm.

All limits, masks, type bits and the status are reached through a simple register port. Register writes take effect on the clock edge. Read data is combinational from the address. A status read clears those latched bits whose condition was false at the last sample.

Top module: `sense_limit_alarm`

## Requirements
- R1: After reset, every low limit reads 0x00, every high limit and hysteresis limit reads 0xFF, the status reads 0x00, the enable mask reads 0x1F, the type register reads 0x00, the mode register reads 0x00, and irq is low.
- R2: A voltage channel (type bit 0) gets its condition set by a sample whose code is strictly below its low limit or strictly above its high limit. That sample sets the channel's status bit. A code equal to either limit sets nothing.
- R3: A latched status bit stays set through samples that are back in range. A status read (reg_rd high at address 20) returns the bits as they were before the edge. It then clears only the bits whose condition was false at the most recent sample.
- R4: A temperature channel (type bit 1) gets its status bit set by a sample strictly above its high limit, in either mode. A code equal to the high limit sets nothing.
- R5: In mode 0, a temperature channel whose condition is active keeps that condition through later samples until a code strictly below its hysteresis limit arrives. Until then, a status read does not clear the bit.
- R6: In mode 1, the status bit of a temperature channel is rewritten at each sample to (code > high limit). The hysteresis limit is not used.
- R7: irq is high exactly when some status bit is set and its bit in the enable mask is also set. Masked bits still read as set in the status.
- R8: A register write to the mode address with data bit 0 equal to 0 forces mode 0 and clears every status bit on that edge.
- R9: Comparisons happen only on cycles where sample_valid is high. A limit write changes no status bit before the next sample.
- R10: Register map (addresses are 5 bits, data is 8 bits):
  - For channel c, address 4c holds the low limit, 4c+1 the high limit and 4c+2 the hysteresis limit.
  - Address 20 holds the status, address 21 the enable mask, address 22 the type bits (1 = temperature), and address 23 the mode in bit 0.
  - Channel c occupies bit c of the status, enable and type registers, and bits 8c+7:8c of sample_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Strobe: a new set of readings is present |
| sample_data | input | 40 | Five packed 8-bit codes, channel c at bits 8c+7:8c |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read strobe (clears status at address 20) |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt: OR of enabled status bits |

## Verification
Writes, samples and status reads all act on the clock edge where their strobe is high. The status and irq therefore show the new value one register stage later, with no further pipeline. Read data depends combinationally on the address. For this reason the bench drives every strobe just after a rising edge and lets exactly one edge pass. It then sets the address to the status register with reg_rd low and compares reg_rdata and irq against its model before the next edge. Status reads are also checked in the cycle before their clearing edge, which confirms that the returned value predates the clear.

// File: rtl/sense_limit_alarm.sv
module sense_limit_alarm #(
  parameter int NCH = 5,
  parameter int DW  = 8,
  parameter int AW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [NCH*DW-1:0] sample_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);

  localparam logic [AW-1:0] A_STAT = AW'(4*NCH);
  localparam logic [AW-1:0] A_EN   = AW'(4*NCH + 1);
  localparam logic [AW-1:0] A_TYPE = AW'(4*NCH + 2);
  localparam logic [AW-1:0] A_MODE = AW'(4*NCH + 3);

  logic [NCH-1:0][DW-1:0] lo_q, hi_q, hy_q;
  logic [NCH-1:0] alarm_q, cond_q, en_q, typ_q;
  logic [NCH-1:0] cond_n, alarm_d, follow;
  logic           mode_q;

  wire rd_stat  = reg_rd && reg_addr == A_STAT;
  wire mode_clr = reg_wr && reg_addr == A_MODE && !reg_wdata[0];

  assign follow = typ_q & {NCH{mode_q}};
  assign irq    = |(alarm_q & en_q);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire [DW-1:0] d     = sample_data[c*DW +: DW];
    wire          below = d < lo_q[c];
    wire          above = d > hi_q[c];
    wire          hold  = !mode_q && cond_q[c] && !(d < hy_q[c]);
    assign cond_n[c] = typ_q[c] ? (above || hold) : (below || above);

    p_volt_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid && !typ_q[c] && (d < lo_q[c] || d > hi_q[c]) && !mode_clr
      |=> alarm_q[c]);

    p_temp_hyst_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid && typ_q[c] && !mode_q && cond_q[c] && d >= hy_q[c] && !mode_clr
      |=> alarm_q[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '1;
      hy_q <= '1;
    end else if (reg_wr) begin
      for (int c = 0; c < NCH; c++) begin
        if (reg_addr == AW'(4*c))     lo_q[c] <= reg_wdata;
        if (reg_addr == AW'(4*c + 1)) hi_q[c] <= reg_wdata;
        if (reg_addr == AW'(4*c + 2)) hy_q[c] <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '1;
      typ_q  <= '0;
      mode_q <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == A_EN)   en_q   <= reg_wdata[NCH-1:0];
      if (reg_addr == A_TYPE) typ_q  <= reg_wdata[NCH-1:0];
      if (reg_addr == A_MODE) mode_q <= reg_wdata[0];
    end
  end

  always_comb begin
    alarm_d = alarm_q;
    if (rd_stat)      alarm_d = alarm_d & cond_q;
    if (sample_valid) alarm_d = (alarm_d & ~follow) | cond_n;
    if (mode_clr)     alarm_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      cond_q  <= '0;
    end else begin
      alarm_q <= alarm_d;
      if (sample_valid) cond_q <= cond_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == AW'(4*c))     reg_rdata = lo_q[c];
      if (reg_addr == AW'(4*c + 1)) reg_rdata = hi_q[c];
      if (reg_addr == AW'(4*c + 2)) reg_rdata = hy_q[c];
    end
    if (reg_addr == A_STAT) reg_rdata = DW'(alarm_q);
    if (reg_addr == A_EN)   reg_rdata = DW'(en_q);
    if (reg_addr == A_TYPE) reg_rdata = DW'(typ_q);
    if (reg_addr == A_MODE) reg_rdata = DW'(mode_q);
  end

  p_mode_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clr |=> alarm_q == '0 && !irq);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid && !rd_stat && !mode_clr |=> $stable(alarm_q));

  p_read_noset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !sample_valid |=> (alarm_q & ~$past(alarm_q)) == '0);

  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_EN && reg_wdata[NCH-1:0] == '0 && !mode_clr |=> !irq);

endmodule

// File: tb/test_sense_limit_alarm.sv
`timescale 1ns/1ps
module test_sense_limit_alarm;
  localparam int NCH = 5;
  localparam logic [4:0] A_STAT = 5'd20, A_EN = 5'd21, A_TYPE = 5'd22, A_MODE = 5'd23;

  logic clk = 0, rst_n = 0;
  logic sample_valid = 0, reg_wr = 0, reg_rd = 0;
  logic [39:0] sample_data = '0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  sense_limit_alarm i_sense_limit_alarm (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_data(sample_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  logic [7:0] m_lo[NCH], m_hi[NCH], m_hy[NCH];
  logic [4:0] m_al, m_cond, m_en, m_typ;
  logic       m_mode;

  function automatic logic mcond(int c, logic [7:0] d);
    if (m_typ[c]) return (d > m_hi[c]) || (!m_mode && m_cond[c] && d >= m_hy[c]);
    return (d < m_lo[c]) || (d > m_hi[c]);
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic peek(string tag);
    reg_addr = A_STAT; reg_rd = 0;
    #1;
    check({tag, " status"}, reg_rdata, {3'b0, m_al});
    check({tag, " irq R7"}, {7'b0, irq}, {7'b0, |(m_al & m_en)});
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin
      if (a == 5'(4*c))     m_lo[c] = d;
      if (a == 5'(4*c + 1)) m_hi[c] = d;
      if (a == 5'(4*c + 2)) m_hy[c] = d;
    end
    if (a == A_EN)   m_en = d[4:0];
    if (a == A_TYPE) m_typ = d[4:0];
    if (a == A_MODE) begin
      m_mode = d[0];
      if (!d[0]) m_al = '0;
    end
    #1 reg_wr = 0;
  endtask

  task automatic smp(logic [39:0] v);
    logic [4:0] cn;
    sample_valid = 1; sample_data = v;
    for (int c = 0; c < NCH; c++) cn[c] = mcond(c, v[c*8 +: 8]);
    @(posedge clk);
    m_al = (m_al & ~(m_typ & {5{m_mode}})) | cn;
    m_cond = cn;
    #1 sample_valid = 0;
  endtask

  task automatic rd_stat(string tag);
    reg_addr = A_STAT; reg_rd = 1;
    #1 check({tag, " read value"}, reg_rdata, {3'b0, m_al});
    @(posedge clk);
    m_al = m_al & m_cond;
    #1 reg_rd = 0;
  endtask

  function automatic logic [39:0] one(int c, logic [7:0] d, logic [7:0] rest);
    logic [39:0] v = {5{rest}};
    v[c*8 +: 8] = d;
    return v;
  endfunction

  initial begin
    #500000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd24681);
    for (int c = 0; c < NCH; c++) begin m_lo[c] = 8'h00; m_hi[c] = 8'hFF; m_hy[c] = 8'hFF; end
    m_al = 0; m_cond = 0; m_en = 5'h1F; m_typ = 0; m_mode = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 / R10: reset values through the register map
    for (int a = 0; a < 24; a++) begin
      logic [7:0] e;
      reg_addr = 5'(a); #1;
      e = (a % 4 == 0) ? 8'h00 : (a % 4 == 3) ? 8'h00 : 8'hFF;
      if (a == 20) e = 8'h00;
      if (a == 21) e = 8'h1F;
      if (a == 22) e = 8'h00;
      if (a == 23) e = 8'h00;
      check($sformatf("R1 R10 reset addr %0d", a), reg_rdata, e);
    end
    check("R1 irq", {7'b0, irq}, 8'h00);

    // R2: voltage window boundaries on channel 0
    wr(5'd0, 8'h40); wr(5'd1, 8'hC0);
    smp(one(0, 8'h40, 8'h80)); peek("R2 equal low");
    smp(one(0, 8'hC0, 8'h80)); peek("R2 equal high");
    smp(one(0, 8'h3F, 8'h80)); peek("R2 below low");
    // R3: still out of range -> read keeps it
    rd_stat("R3 read1"); peek("R3 kept");
    smp(one(0, 8'h80, 8'h80)); peek("R3 latched");
    rd_stat("R3 read2"); peek("R3 cleared");
    smp(one(0, 8'hC1, 8'h80)); peek("R2 above high");

    // R8: mode 0 write clears
    wr(A_MODE, 8'h00); peek("R8 cleared");

    // R9: limit write alone sets nothing
    smp(one(0, 8'h80, 8'h80)); rd_stat("R9 prep");
    wr(5'd0, 8'h90); peek("R9 no change on write");
    smp(one(0, 8'h80, 8'h80)); peek("R9 applied at sample");
    wr(A_MODE, 8'h00); wr(5'd0, 8'h00);

    // R4 / R5: temperature channel 1 in mode 0
    wr(A_TYPE, 8'h02); wr(5'd5, 8'h60); wr(5'd6, 8'h50);
    smp(one(1, 8'h60, 8'h10)); peek("R4 equal high");
    smp(one(1, 8'h61, 8'h10)); peek("R4 above high");
    smp(one(1, 8'h50, 8'h10)); rd_stat("R5 at hyst"); peek("R5 held");
    smp(one(1, 8'h4F, 8'h10)); peek("R5 latched");
    rd_stat("R5 below hyst"); peek("R5 cleared");

    // R6: mode 1 follows high limit
    wr(A_MODE, 8'h01);
    smp(one(1, 8'h61, 8'h10)); peek("R6 set");
    smp(one(1, 8'h5A, 8'h10)); peek("R6 clear without hyst");
    smp(one(1, 8'h61, 8'h10));
    smp(one(1, 8'h60, 8'h10)); peek("R6 equal clears");

    // R7: mask
    smp(one(1, 8'hF0, 8'h10));
    wr(A_EN, 8'h00); peek("R7 masked");
    wr(A_EN, 8'h02); peek("R7 unmasked");
    wr(A_MODE, 8'h00); peek("R8 from mode1");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom % 8;
      int c  = $urandom % NCH;
      case (op)
        0, 1, 2: begin
          logic [39:0] v;
          for (int k = 0; k < NCH; k++) v[k*8 +: 8] = 8'($urandom);
          smp(v);
        end
        3: wr(5'(4*c + ($urandom % 3)), 8'($urandom));
        4: wr(A_EN, 8'($urandom));
        5: wr(A_TYPE, 8'($urandom));
        6: wr(A_MODE, ($urandom % 4 == 0) ? 8'h00 : 8'h01);
        default: rd_stat("R3 R5 random read");
      endcase
      peek("R2 R4 R6 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule